// File: doc/BRIEF.md
# Serial Memory Write-Guard and Status Byte

This block sits between the command decoder and the programming sequencer of a small serial non-volatile memory. It keeps the write-enable latch and the two-bit protect level. It builds the eight-bit status byte that a status-read command shifts out. For every address that the command engine wants to program, it decides whether the write is allowed.

The decoder sends one-cycle pulses: enable, disable, and status-write with its data byte. The sequencer reports two things: a busy level while a program cycle runs, and a pulse when that cycle ends. The hardware write-protect pin is sampled directly. A status write is allowed only when the latch is set, the pin is high and no cycle is running. When it is allowed, the block updates the protect level itself and pulses a grant so that the sequencer can start its timed cycle. The protect bits are kept in a plain register whose reset value is a parameter, so any protect level can be the power-up state. All outputs are registered and appear one clock after the state or input that sets them.

Top module: `wp_status_ctrl`

## Requirements
- R1: During reset and in the first cycles after it, the latch is clear, the protect level equals the parameter BP_RST, `status_o` reads {4'b0000, BP_RST, 2'b00}, and `wr_permit_o` and `wrsr_grant_o` are 0.
- R2: An enable pulse sets the write-enable latch only when `wp_pin_i` is high. With the pin low, the pulse has no effect.
- R3: A disable pulse clears the latch.
- R4: A program-end pulse clears the latch, whatever other pulse arrives in the same cycle.
- R5: When no cycle is running, `status_o` bit 0 is 0, bit 1 shows the latch, bit 2 is protect-level bit 0, bit 3 is protect-level bit 1, and bits 7:4 are 0. The byte shows the state one clock later.
- R6: While `prog_busy_i` is high, `status_o` reads 8'hFF one clock later.
- R7: An accepted status write copies bits 3:2 of `wrsr_byte_i` into the protect level and ignores all other bits. `wrsr_grant_o` pulses high for one cycle on the following clock.
- R8: A status write is ignored, and gives no grant, when the latch is clear or `wp_pin_i` is low.
- R9: An address is protected as follows. Level 0 protects nothing. Level 1 protects the top quarter (two address MSBs both 1; with 13 bits, 0x1800–0x1FFF). Level 2 protects the top half (address MSB 1; 0x1000–0x1FFF). Level 3 protects every address.
- R10: `wr_permit_o` equals latch AND `wp_pin_i` AND not busy AND not protected(`wr_addr_i`), registered with one clock of latency.
- R11: While `prog_busy_i` is high, enable, disable and status-write pulses are ignored, and `wr_permit_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_pin_i | input | 1 | Hardware write-protect pin; 1 allows writes |
| prog_busy_i | input | 1 | Program cycle in progress |
| prog_end_i | input | 1 | Pulse when a program cycle completes |
| cmd_wren_i | input | 1 | Decoded write-enable command pulse |
| cmd_wrdi_i | input | 1 | Decoded write-disable command pulse |
| cmd_wrsr_i | input | 1 | Status-write data byte received pulse |
| wrsr_byte_i | input | 8 | Status-write data byte |
| wr_addr_i | input | ADDR_W | Candidate array write address |
| wr_permit_o | output | 1 | Array write to `wr_addr_i` is allowed |
| wrsr_grant_o | output | 1 | Status write accepted; start a program cycle |
| status_o | output | 8 | Status byte for readout |

## Verification
The assertions check these properties on every cycle: the busy-time all-ones status byte, and the absence of permit when the pin is low, when a cycle is running, or at full protection. They also check that the latch is cleared at program end, that the latch rises only with the pin high, and that the protect level holds while the pin is low or a cycle runs. Only the bench's scenarios can show the exact protect boundaries at each level, the bit-selective update of the status write, and the order of effects across command sequences. To do this, the bench sweeps addresses at every protect level and compares each result with boundaries it computes itself.

// File: rtl/wpst_pkg.sv
package wpst_pkg;
  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_lvl_e;

  localparam int SB_W    = 8;
  localparam int SB_BUSY = 0;
  localparam int SB_WEL  = 1;
  localparam int SB_BP0  = 2;
  localparam int SB_BP1  = 3;
endpackage

// File: rtl/wel_bp_regs.sv
module wel_bp_regs
  import wpst_pkg::*;
#(
  parameter logic [1:0] BP_RST = 2'b00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wp_i,
  input  logic            busy_i,
  input  logic            end_i,
  input  logic            wren_i,
  input  logic            wrdi_i,
  input  logic            wrsr_i,
  input  logic [SB_W-1:0] wrsr_d_i,
  output logic            wel_o,
  output prot_lvl_e       bp_o,
  output logic            wrsr_ok_o
);
  logic      wel_q;
  prot_lvl_e bp_q;
  logic      ok_q;
  logic      gate;
  logic      take_sr;
  logic      unused_bits;

  assign gate        = wp_i & ~busy_i;
  assign take_sr     = wrsr_i & wel_q & gate;
  assign unused_bits = ^{wrsr_d_i[SB_W-1:SB_BP1+1], wrsr_d_i[SB_BP0-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q <= 1'b0;
      bp_q  <= prot_lvl_e'(BP_RST);
      ok_q  <= 1'b0;
    end else begin
      ok_q <= take_sr;
      if (take_sr) bp_q <= prot_lvl_e'(wrsr_d_i[SB_BP1:SB_BP0]);
      if (end_i || (wrdi_i && !busy_i)) wel_q <= 1'b0;
      else if (wren_i && gate)          wel_q <= 1'b1;
    end
  end

  assign wel_o     = wel_q;
  assign bp_o      = bp_q;
  assign wrsr_ok_o = ok_q;

  AST_WEL_END_CLR:  assert property (@(posedge clk) disable iff (rst) end_i |=> !wel_q);           // R4
  AST_WEL_NEEDS_WP: assert property (@(posedge clk) disable iff (rst) $rose(wel_q) |-> $past(wp_i)); // R2
  AST_BP_LOCK_WP:   assert property (@(posedge clk) disable iff (rst) !wp_i |=> $stable(bp_q));     // R8
  AST_BP_LOCK_BUSY: assert property (@(posedge clk) disable iff (rst) busy_i |=> $stable(bp_q));    // R11
endmodule

// File: rtl/range_guard.sv
module range_guard
  import wpst_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic [AW-1:0] addr_i,
  input  prot_lvl_e     lvl_i,
  output logic          hit_o
);
  localparam int TOP = AW - 1;

  always_comb begin
    case (lvl_i)
      PROT_NONE: hit_o = 1'b0;
      PROT_QTR:  hit_o = &addr_i[TOP -: 2];
      PROT_HALF: hit_o = addr_i[TOP];
      PROT_ALL:  hit_o = 1'b1;
      default:   hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/status_fmt.sv
module status_fmt
  import wpst_pkg::*;
#(
  parameter logic [1:0] BP_RST = 2'b00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            busy_i,
  input  logic            wel_i,
  input  prot_lvl_e       bp_i,
  output logic [SB_W-1:0] sts_o
);
  logic [SB_W-1:0] sts_q;
  logic [SB_W-1:0] sts_d;
  logic [SB_W-1:0] sts_rst;

  always_comb begin
    sts_rst         = '0;
    sts_rst[SB_BP0] = BP_RST[0];
    sts_rst[SB_BP1] = BP_RST[1];
    if (busy_i) begin
      sts_d = '1;
    end else begin
      sts_d          = '0;
      sts_d[SB_WEL]  = wel_i;
      sts_d[SB_BP0]  = bp_i[0];
      sts_d[SB_BP1]  = bp_i[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sts_q <= sts_rst;
    else     sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  AST_BUSY_ALL_ONES: assert property (@(posedge clk) disable iff (rst) busy_i |=> (sts_q == '1));           // R6
  AST_IDLE_HI_ZERO:  assert property (@(posedge clk) disable iff (rst) !busy_i |=> (sts_q[SB_W-1:4] == '0)); // R5
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
  import wpst_pkg::*;
#(
  parameter int         ADDR_W = 13,
  parameter logic [1:0] BP_RST = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_pin_i,
  input  logic              prog_busy_i,
  input  logic              prog_end_i,
  input  logic              cmd_wren_i,
  input  logic              cmd_wrdi_i,
  input  logic              cmd_wrsr_i,
  input  logic [7:0]        wrsr_byte_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              wr_permit_o,
  output logic              wrsr_grant_o,
  output logic [7:0]        status_o
);
  logic      wel;
  prot_lvl_e bp;
  logic      hit;
  logic      permit_q;

  wel_bp_regs #(.BP_RST(BP_RST)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wp_i     (wp_pin_i),
    .busy_i   (prog_busy_i),
    .end_i    (prog_end_i),
    .wren_i   (cmd_wren_i),
    .wrdi_i   (cmd_wrdi_i),
    .wrsr_i   (cmd_wrsr_i),
    .wrsr_d_i (wrsr_byte_i),
    .wel_o    (wel),
    .bp_o     (bp),
    .wrsr_ok_o(wrsr_grant_o)
  );

  range_guard #(.AW(ADDR_W)) u_guard (
    .addr_i(wr_addr_i),
    .lvl_i (bp),
    .hit_o (hit)
  );

  status_fmt #(.BP_RST(BP_RST)) u_fmt (
    .clk   (clk),
    .rst   (rst),
    .busy_i(prog_busy_i),
    .wel_i (wel),
    .bp_i  (bp),
    .sts_o (status_o)
  );

  always_ff @(posedge clk) begin
    if (rst) permit_q <= 1'b0;
    else     permit_q <= wel & wp_pin_i & ~prog_busy_i & ~hit;
  end

  assign wr_permit_o = permit_q;

  AST_NO_PERMIT_WP:   assert property (@(posedge clk) disable iff (rst) !wp_pin_i |=> !wr_permit_o);        // R10
  AST_NO_PERMIT_BUSY: assert property (@(posedge clk) disable iff (rst) prog_busy_i |=> !wr_permit_o);      // R11
  AST_FULL_LOCK:      assert property (@(posedge clk) disable iff (rst) (bp == PROT_ALL) |=> !wr_permit_o); // R9
endmodule

// File: tb/sim_wp_status_ctrl.sv
module sim_wp_status_ctrl;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wp = 1'b0, busy = 1'b0, pend = 1'b0;
  logic          wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0;
  logic [7:0]    sbyte = 8'h00;
  logic [AW-1:0] addr = '0;
  logic          permit, grant;
  logic [7:0]    sts;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  wp_status_ctrl #(.ADDR_W(AW), .BP_RST(2'b00)) u0 (
    .clk(clk), .rst(rst), .wp_pin_i(wp), .prog_busy_i(busy), .prog_end_i(pend),
    .cmd_wren_i(wren), .cmd_wrdi_i(wrdi), .cmd_wrsr_i(wrsr), .wrsr_byte_i(sbyte),
    .wr_addr_i(addr), .wr_permit_o(permit), .wrsr_grant_o(grant), .status_o(sts)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // state change at the pulse edge, status register one edge later
  task automatic pulse_wren(); wren = 1; step(); wren = 0; step(); endtask
  task automatic pulse_wrdi(); wrdi = 1; step(); wrdi = 0; step(); endtask
  task automatic pulse_end();  pend = 1; step(); pend = 0; step(); endtask
  task automatic pulse_wrsr(input logic [7:0] b);
    sbyte = b; wrsr = 1; step(); wrsr = 0; step();
  endtask

  function automatic logic [7:0] exp_sts(input logic wel, input logic [1:0] lvl);
    return {4'b0000, lvl, wel, 1'b0};
  endfunction

  function automatic int lo_bound(input int lvl);
    case (lvl)
      0: return 8192;
      1: return 6144;
      2: return 4096;
      default: return 0;
    endcase
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R1 status in reset", sts, 8'h00);
    rst = 0;
    step(); step();
    chk("R1 status after reset", sts, exp_sts(0, 2'b00));
    chk("R1 permit after reset", permit, 0);
    chk("R1 grant after reset", grant, 0);

    // R2: enable needs the pin
    wp = 0; pulse_wren();
    chk("R2 wren ignored pin low", sts, exp_sts(0, 2'b00));
    wp = 1; pulse_wren();
    chk("R2 wren sets latch", sts, exp_sts(1, 2'b00));

    // R3
    pulse_wrdi();
    chk("R3 wrdi clears latch", sts, exp_sts(0, 2'b00));

    // R6 / R11: busy reading and ignored commands
    pulse_wren();
    busy = 1; step(); step();
    chk("R6 busy status ones", sts, 8'hFF);
    chk("R11 permit low when busy", permit, 0);
    pulse_wrdi();
    pulse_wrsr(8'h0C);
    chk("R11 grant absent when busy", grant, 0);
    busy = 0; step(); step();
    chk("R11 wrdi/wrsr ignored when busy", sts, exp_sts(1, 2'b00));
    pulse_end();
    pulse_wrdi();
    busy = 1; pulse_wren(); busy = 0; step(); step();
    chk("R11 wren ignored when busy", sts, exp_sts(0, 2'b00));

    // R4: end pulse wins over a simultaneous enable
    pulse_wren();
    pend = 1; wren = 1; step(); pend = 0; wren = 0; step();
    chk("R4 end clears latch", sts, exp_sts(0, 2'b00));

    // R8: status write ignored
    pulse_wrsr(8'hFF);
    chk("R8 wrsr ignored latch clear", sts, exp_sts(0, 2'b00));
    pulse_wren(); wp = 0;
    sbyte = 8'h0C; wrsr = 1; step(); wrsr = 0;
    chk("R8 no grant pin low", grant, 0);
    step();
    chk("R8 wrsr ignored pin low", sts, exp_sts(1, 2'b00));
    wp = 1;

    // R7: bit-selective update and grant pulse
    sbyte = 8'hF7; wrsr = 1; step(); wrsr = 0;
    chk("R7 grant pulse", grant, 1);
    step();
    chk("R7 grant one cycle", grant, 0);
    chk("R7 R5 bp from bits 3:2", sts, exp_sts(1, 2'b01));
    pulse_end();
    chk("R4 end after wrsr", sts, exp_sts(0, 2'b01));

    // R9 / R10: address sweep at each level
    for (int lvl = 0; lvl < 4; lvl++) begin
      pulse_wren();
      pulse_wrsr({4'b1010, lvl[1:0], 2'b11});
      pulse_end();
      pulse_wren();
      chk("R5 R7 level status", sts, exp_sts(1, lvl[1:0]));
      for (int p = 0; p < 2; p++) begin
        wp = p[0];
        for (int i = 0; i < 136; i++) begin
          int a;
          if (i < 128) a = i * 64;
          else case (i)
            128: a = 16'h0FFF; 129: a = 16'h1000; 130: a = 16'h17FF;
            131: a = 16'h1800; 132: a = 16'h1FFF; 133: a = 0;
            134: a = 16'h0001; default: a = 16'h103F;
          endcase
          addr = a[AW-1:0];
          step();
          chk("R9 R10 permit sweep", permit, (p == 1 && a < lo_bound(lvl)) ? 1 : 0);
        end
      end
      wp = 1;
      pulse_wrdi();
      addr = '0; step();
      chk("R10 permit needs latch", permit, 0);
    end

    // back to level 0 and busy gating of permit
    pulse_wren(); pulse_wrsr(8'h00); pulse_end(); pulse_wren();
    addr = '0; step();
    chk("R10 permit open level 0", permit, 1);
    busy = 1; step();
    chk("R11 permit blocked busy", permit, 0);
    busy = 0; step();
    chk("R10 permit returns", permit, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule